// File: doc/BRIEF.md
# Overcurrent Duration Window Counter

This block measures how long the load current of a switched power channel spends inside an overcurrent window. It counts one step per clock while the channel is commanded on and the relevant current comparator is active. Clocks during which the channel is off add nothing, so a channel switched with PWM takes proportionally longer to reach the limit than a channel that is fully on. When the accumulated count passes a programmable window width, the block raises a turn-off request. The request stays raised until an auto-retry or a delatch pulse clears it.

Two operating styles are supported. In lamp mode the window is the high-threshold comparator, and every accepted auto-retry starts the count from zero. In motor mode the window is the low-threshold comparator. There, auto-retries leave the count untouched, and the count is cleared instead after an on-period in which the low threshold was never crossed. That clear takes effect on the clock at which the on-period ends. A retry budget decides when a trip becomes a latched overcurrent fault that only a delatch can clear.

Top module: `ocw_timer`

## Requirements
- R1: `count` increases by one on a clock only when `chan_on` is 1, the mode's window comparator is 1 and `trip` is 0; otherwise it holds, unless one of the clears in R5, R6 or R8 applies.
- R2: The window comparator is `oc_hi` in lamp mode (`motor_mode` = 0) and `oc_lo` in motor mode (`motor_mode` = 1); the other comparator has no effect on counting.
- R3: With a window width W below the counter maximum, `trip` rises on the same clock that `count` first becomes W+1, which is after W+1 counting clocks.
- R4: Once `trip` is 1, it stays 1 and `count` stops advancing until an accepted retry or a delatch.
- R5: A `delatch` pulse clears `count`, `trip`, `oc_latched` and the number of retries used, on the following clock.
- R6: In lamp mode, a `retry_evt` while `trip` is 1 and `oc_latched` is 0 clears both `trip` and `count`.
- R7: In motor mode, such a retry clears `trip` but keeps `count`, so the next counting clock raises `trip` again at once.
- R8: In motor mode, an on-period during which `oc_lo` was never 1 clears `count` on the clock at which `chan_on` falls. The count is not cleared while that on-period is still running.
- R9: PWM off-times only pause the count. In lamp mode, and in motor mode after an on-period that saw overcurrent, the count resumes from its previous value.
- R10: `count` saturates at its all-ones value and never wraps; with W equal to that value, `trip` never rises.
- R11: `oc_latched` rises together with `trip` when `retry_en` is 0, or when the number of accepted retries already equals `retry_budget`. While `oc_latched` is 1, `retry_evt` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_on | input | 1 | Channel commanded on |
| oc_lo | input | 1 | Current above low overcurrent threshold |
| oc_hi | input | 1 | Current above high overcurrent threshold |
| motor_mode | input | 1 | 0 = lamp mode, 1 = motor mode |
| win_width | input | CNT_W | Window width in clocks |
| delatch | input | 1 | Fault clear pulse |
| retry_evt | input | 1 | Auto-retry event pulse |
| retry_en | input | 1 | Auto-retry enabled |
| retry_budget | input | RETRY_W | Retries allowed before latching |
| trip | output | 1 | Turn-off request |
| oc_latched | output | 1 | Overcurrent fault latched |
| count | output | CNT_W | Accumulated overcurrent duration |

## Verification
The main function is swept over every window width of a 4-bit counter, in both modes. It is run with the channel fully on and with two PWM duty patterns, and the trip clock must track the number of on-clocks rather than elapsed clocks, which separates pausing from resetting or free-running. The all-ones width shows saturation against wrapping. Directed sequences distinguish the lamp-mode and motor-mode retry behaviour, the deferred clear after a clean motor on-period against a clear at the start of that period, the comparator selection per mode, and the point at which the retry budget turns a trip into a latched fault.

// File: rtl/ocw_pkg.sv
package ocw_pkg;

    typedef enum logic {
        MODE_LAMP  = 1'b0,
        MODE_MOTOR = 1'b1
    } ocw_mode_e;

    typedef struct packed {
        logic hit;         // counting clock
        logic fall;        // chan_on falling edge
        logic clean_fall;  // motor on-period ended without overcurrent
    } ocw_win_s;

    typedef struct packed {
        logic trip;
        logic latched;
    } ocw_flags_s;

endpackage

// File: rtl/ocw_window.sv
module ocw_window
    import ocw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      chan_on,
    input  logic      oc_lo,
    input  logic      oc_hi,
    input  ocw_mode_e mode,
    input  logic      trip,
    output ocw_win_s  win
);
    logic on_q;
    logic clean_q;
    logic in_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q    <= 1'b0;
            clean_q <= 1'b0;
        end else begin
            on_q <= chan_on;
            if (chan_on && !on_q)
                clean_q <= !oc_lo;
            else if (chan_on && oc_lo)
                clean_q <= 1'b0;
        end
    end

    always_comb begin
        in_win         = (mode == MODE_MOTOR) ? oc_lo : oc_hi;
        win.hit        = chan_on && !trip && in_win;
        win.fall       = on_q && !chan_on;
        win.clean_fall = win.fall && clean_q && (mode == MODE_MOTOR);
    end

    AST_CLEAN_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        win.clean_fall |-> ($past(chan_on) && !chan_on)) else $error("clean clear off edge"); // R8

endmodule

// File: rtl/ocw_accum.sv
module ocw_accum #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             clear,
    input  logic [CNT_W-1:0] win_width,
    output logic [CNT_W-1:0] cnt,
    output logic             exceed
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             adv;

    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        adv     = hit && (cnt_q <= win_width);
        exceed  = hit && (cnt_inc > win_width);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_inc;
    end

    assign cnt = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> cnt_q >= $past(cnt_q)) else $error("count wrapped"); // R10
    AST_PAUSE_OFF: assert property (@(posedge clk) disable iff (rst)
        (!hit && !clear) |=> $stable(cnt_q)) else $error("count moved off-window"); // R1

endmodule

// File: rtl/ocw_trip.sv
module ocw_trip
    import ocw_pkg::*;
#(
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exceed,
    input  logic               retry_evt,
    input  logic               retry_en,
    input  logic [RETRY_W-1:0] retry_budget,
    input  logic               delatch,
    output ocw_flags_s         flags,
    output logic               retry_take
);
    localparam logic [RETRY_W-1:0] USED_MAX = {RETRY_W{1'b1}};

    ocw_flags_s         fl_q;
    logic [RETRY_W-1:0] used_q;
    logic               budget_gone;

    always_comb begin
        retry_take  = retry_evt && fl_q.trip && !fl_q.latched;
        budget_gone = !retry_en || (used_q >= retry_budget);
    end

    always_ff @(posedge clk) begin
        if (rst || delatch) begin
            fl_q   <= '0;
            used_q <= '0;
        end else if (retry_take) begin
            fl_q.trip <= 1'b0;
            if (used_q != USED_MAX)
                used_q <= used_q + 1'b1;
        end else if (exceed && !fl_q.trip) begin
            fl_q.trip <= 1'b1;
            if (budget_gone)
                fl_q.latched <= 1'b1;
        end
    end

    assign flags = fl_q;

    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fl_q.trip && !delatch && !retry_take) |=> fl_q.trip) else $error("trip dropped"); // R4
    AST_LATCH_BUDGET: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_q.latched) |-> $past(!retry_en || (used_q >= retry_budget))) else $error("early latch"); // R11
    AST_LATCH_WITH_TRIP: assert property (@(posedge clk) disable iff (rst)
        fl_q.latched |-> fl_q.trip) else $error("latched without trip"); // R11

endmodule

// File: rtl/ocw_timer.sv
module ocw_timer
    import ocw_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chan_on,
    input  logic               oc_lo,
    input  logic               oc_hi,
    input  logic               motor_mode,
    input  logic [CNT_W-1:0]   win_width,
    input  logic               delatch,
    input  logic               retry_evt,
    input  logic               retry_en,
    input  logic [RETRY_W-1:0] retry_budget,
    output logic               trip,
    output logic               oc_latched,
    output logic [CNT_W-1:0]   count
);
    ocw_mode_e  mode;
    ocw_win_s   win;
    ocw_flags_s flags;
    logic       exceed;
    logic       retry_take;
    logic       cnt_clear;

    assign mode = ocw_mode_e'(motor_mode);

    ocw_window u_window (
        .clk     (clk),
        .rst     (rst),
        .chan_on (chan_on),
        .oc_lo   (oc_lo),
        .oc_hi   (oc_hi),
        .mode    (mode),
        .trip    (flags.trip),
        .win     (win)
    );

    always_comb
        cnt_clear = delatch
                 || (retry_take && (mode == MODE_LAMP))
                 || win.clean_fall;

    ocw_accum #(.CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .hit       (win.hit),
        .clear     (cnt_clear),
        .win_width (win_width),
        .cnt       (count),
        .exceed    (exceed)
    );

    ocw_trip #(.RETRY_W(RETRY_W)) u_trip (
        .clk          (clk),
        .rst          (rst),
        .exceed       (exceed),
        .retry_evt    (retry_evt),
        .retry_en     (retry_en),
        .retry_budget (retry_budget),
        .delatch      (delatch),
        .flags        (flags),
        .retry_take   (retry_take)
    );

    assign trip       = flags.trip;
    assign oc_latched = flags.latched;

    AST_DELATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        delatch |=> (count == '0 && !trip && !oc_latched)) else $error("delatch incomplete"); // R5
    AST_MOTOR_RETRY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (retry_take && motor_mode && !delatch && !win.clean_fall) |=> (count == $past(count) && !trip))
        else $error("motor retry altered count"); // R7
    AST_TRIP_OVER_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(trip) |-> count > $past(win_width)) else $error("trip below width"); // R3

endmodule

// File: tb/sim_ocw_timer.sv
module sim_ocw_timer;
    localparam int CW = 4;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chan_on = 1'b0, oc_lo = 1'b0, oc_hi = 1'b0, motor_mode = 1'b0;
    logic [CW-1:0] win_width = '0;
    logic          delatch = 1'b0, retry_evt = 1'b0, retry_en = 1'b0;
    logic [RW-1:0] retry_budget = '0;
    logic          trip, oc_latched;
    logic [CW-1:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ocw_timer #(.CNT_W(CW), .RETRY_W(RW)) u0 (
        .clk(clk), .rst(rst), .chan_on(chan_on), .oc_lo(oc_lo), .oc_hi(oc_hi),
        .motor_mode(motor_mode), .win_width(win_width), .delatch(delatch),
        .retry_evt(retry_evt), .retry_en(retry_en), .retry_budget(retry_budget),
        .trip(trip), .oc_latched(oc_latched), .count(count)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_delatch();
        delatch = 1'b1;
        step();
        delatch = 1'b0;
    endtask

    task automatic retry();
        retry_evt = 1'b1;
        step();
        retry_evt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        chk("R5 reset count", count, 0);
        chk("R5 reset trip", trip, 0);
        chk("R5 reset latched", oc_latched, 0);

        // R3 R9 sweep: every width, both modes, full-on and PWM patterns
        for (int m = 0; m < 2; m++) begin
            for (int off = 0; off < 3; off++) begin
                for (int w = 0; w < 15; w++) begin
                    int oncnt;
                    int ph;
                    motor_mode = m[0];
                    win_width  = w[CW-1:0];
                    oc_lo = 1'b1; oc_hi = 1'b1; retry_en = 1'b0;
                    chan_on = 1'b0;
                    do_delatch();
                    oncnt = 0;
                    ph = 0;
                    while (oncnt < w + 3) begin
                        chan_on = (ph == 0);
                        step();
                        if (ph == 0) oncnt++;
                        ph = (ph >= off) ? 0 : ph + 1;
                        chk("R3 R9 sweep count", count, (oncnt < w + 1) ? oncnt : w + 1);
                        chk("R3 R4 sweep trip", trip, (oncnt >= w + 1) ? 1 : 0);
                        chk("R11 latch no retry", oc_latched, (oncnt >= w + 1) ? 1 : 0);
                    end
                end
            end
        end

        // R10 saturation at width = all ones
        motor_mode = 1'b0; win_width = 4'hF; chan_on = 1'b1; oc_hi = 1'b1;
        do_delatch();
        repeat (20) step();
        chk("R10 saturate count", count, 15);
        chk("R10 no trip at max width", trip, 0);

        // R2 comparator selection
        win_width = 4'd9; oc_hi = 1'b0; oc_lo = 1'b1; motor_mode = 1'b0;
        do_delatch();
        repeat (3) step();
        chk("R2 lamp ignores oc_lo", count, 0);
        motor_mode = 1'b1; oc_hi = 1'b1; oc_lo = 1'b0;
        do_delatch();
        repeat (3) step();
        chk("R2 motor ignores oc_hi", count, 0);
        oc_lo = 1'b1;
        repeat (3) step();
        chk("R2 motor counts oc_lo", count, 3);

        // R6 R11 lamp retries with budget 2, width 3
        motor_mode = 1'b0; win_width = 4'd3; retry_en = 1'b1; retry_budget = 2'd2;
        chan_on = 1'b1; oc_hi = 1'b1; oc_lo = 1'b1;
        do_delatch();
        for (int t = 0; t < 3; t++) begin
            repeat (4) step();
            chk("R3 retry-cycle trip", trip, 1);
            chk("R11 latch vs budget", oc_latched, (t == 2) ? 1 : 0);
            if (t < 2) begin
                retry();
                chk("R6 lamp retry clears trip", trip, 0);
                chk("R6 lamp retry clears count", count, 0);
            end
        end
        retry();
        chk("R11 latched ignores retry", trip, 1);
        chk("R11 latched stays", oc_latched, 1);
        do_delatch();
        chk("R5 delatch count", count, 0);
        chk("R5 delatch trip", trip, 0);
        chk("R5 delatch latched", oc_latched, 0);

        // R7 motor retry keeps count, retrips at next hit
        motor_mode = 1'b1; win_width = 4'd2; retry_budget = 2'd3;
        repeat (3) step();
        chk("R7 motor trip", trip, 1);
        oc_lo = 1'b0;
        retry();
        chk("R7 motor retry clears trip", trip, 0);
        chk("R7 motor retry keeps count", count, 3);
        step();
        chk("R7 no retrip without current", trip, 0);
        oc_lo = 1'b1;
        step();
        chk("R7 immediate retrip", trip, 1);
        chk("R7 count held", count, 3);

        // R8 R9 clean on-period in motor mode, then in lamp mode
        for (int m = 1; m >= 0; m--) begin
            motor_mode = m[0]; win_width = 4'd12; retry_en = 1'b0;
            chan_on = 1'b1; oc_lo = 1'b1; oc_hi = 1'b1;
            do_delatch();
            repeat (3) step();
            chan_on = 1'b0;
            step();
            chk("R9 on-period with overcurrent keeps count", count, 3);
            oc_lo = 1'b0; oc_hi = 1'b0; chan_on = 1'b1;
            repeat (2) step();
            chk("R8 no clear during on-period", count, 3);
            chan_on = 1'b0;
            step();
            chk(m == 1 ? "R8 motor clear at fall" : "R9 lamp keeps count", count, m == 1 ? 0 : 3);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule